// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block converts single read and write requests from an on-chip master into cycles on an asynchronous external bus that is divided into four chip-select spaces. The space is chosen from two bits of the request address. For that space the block drives an active-low chip select, an active-low read strobe, and two active-low write strobes (upper byte and lower byte). It also drives the address and the write data together with a data output enable.

An 8-bit configuration register holds two settings for each space. The first setting is a spacing bit. When it is set, the block puts exactly one dead cycle between two accesses to the same space that would otherwise follow each other directly. The second setting is a guard bit. When it is set, the chip select opens one cycle before the strobe and closes one cycle after it. The read and write strobes then sit strictly inside the chip-select window, and write data stays driven through the closing cycle, which gives extra hold time.

The master presents a request and holds it until it sees a one-cycle acknowledge. When neither a dead cycle nor a guard cycle is due, the strobe cycle is the same cycle in which the request first appears. A master that presents its next request in the cycle after the acknowledge therefore gets back-to-back bus cycles.

Top module: `ebus_strobe_seq`

## Requirements
- R1: During and directly after reset, every chip select, the read strobe and both write strobes are high (inactive), bus_doe is 0 and req_ack is 0.
- R2: The target space is req_addr[SEL_LSB+1:SEL_LSB], and bus_cs_n bit n (active low) belongs to space n. At most one chip select is low in any cycle, and none is low in a cycle with no bus activity.
- R3: If a space has its guard bit at 0 and no dead cycle is due, a request is served in the cycle it first appears: chip select, address and strobe are active in that cycle, req_ack is 1 in that cycle, and the access is complete.
- R4: If a space has its guard bit at 1, an access takes three cycles: a lead cycle with only chip select low, a strobe cycle, and a trail cycle with only chip select low. bus_addr holds the request address in all three cycles.
- R5: Two accesses are consecutive when the second request is present in the cycle right after the last cycle of the first access. Two consecutive accesses to the same space get exactly one cycle with all chip selects and strobes inactive between them if that space's spacing bit is 1, and no such cycle if the bit is 0. Accesses to different spaces, or accesses that are not consecutive, never get one.
- R6: In the strobe cycle, a read (req_write=0) drives bus_rd_n low. A write (req_write=1) drives bus_wrh_n low if req_be[1] is 1 and bus_wrl_n low if req_be[0] is 1.
- R7: For a write, bus_doe is 1 and bus_dout carries req_wdata in every cycle in which chip select is low, including the trail cycle. bus_doe is 0 at all other times.
- R8: req_ack is high for exactly one cycle per access, in the strobe cycle. For a read, bus_din is sampled at the end of that cycle and appears on req_rdata from the next cycle until the next read completes.
- R9: The configuration register resets to 8'hFF. Bits 7..4 are the spacing bits for spaces 3..0, and bits 3..0 are the guard bits for spaces 3..0. A write through cfg_we/cfg_wdata appears on cfg_rdata in the next cycle.
- R10: A configuration write is used only by bus accesses that begin after the write cycle. An access that has already begun keeps the guard setting it began with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Current configuration value |
| req_valid | input | 1 | Request present, held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address; bits [SEL_LSB+1:SEL_LSB] select the space |
| req_be | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | One-cycle acknowledge in the strobe cycle |
| req_rdata | output | DW | Read data captured at the end of the read strobe cycle |
| bus_cs_n | output | 4 | Chip selects, active low, bit n = space n |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wrh_n | output | 1 | Upper-byte write strobe, active low |
| bus_wrl_n | output | 1 | Lower-byte write strobe, active low |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | External write data |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | DW | External read data |

## Verification
The dead cycle is the hardest case to reach from the ports. It only appears when the next request is already waiting in the exact cycle after the previous access ends, both accesses target the same space, and that space's spacing bit is 1. The stimulus therefore issues requests back to back, without any free cycle in between, and varies three things: the space pair, the spacing bits, and the guard bits (because with guarding on, the end of an access moves to the trail cycle). A configuration write placed in the lead cycle of a guarded access confirms that the trail still follows and that only the next access sees the new value.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int NSPACE = 4;
    localparam int SEL_W  = $clog2(NSPACE);
    localparam int CFG_W  = 2 * NSPACE;

    // Bus-side phase of the current cycle
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LEAD   = 2'd1,
        PH_STROBE = 2'd2,
        PH_TRAIL  = 2'd3
    } phase_e;

    // Registered sequencer state
    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_STROBE = 2'd1,
        ST_TRAIL  = 2'd2
    } state_e;

    typedef struct packed {
        logic             write;
        logic [1:0]       be;
        logic [SEL_W-1:0] space;
    } req_ctl_t;

    // Spacing bits live in the upper half of the configuration word
    function automatic logic [NSPACE-1:0] spacing_bits(input logic [CFG_W-1:0] cfg);
        return cfg[NSPACE +: NSPACE];
    endfunction

    // Guard bits live in the lower half
    function automatic logic [NSPACE-1:0] guard_bits(input logic [CFG_W-1:0] cfg);
        return cfg[0 +: NSPACE];
    endfunction

    function automatic logic [NSPACE-1:0] space_onehot(input logic [SEL_W-1:0] sp);
        logic [NSPACE-1:0] v;
        v = '0;
        v[sp] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/ebus_cfg_reg.sv
module ebus_cfg_reg
    import ebus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '1;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end

    a_r9_reset_all_ones: assert property (@(posedge clk)
        rst |=> (cfg_q == {CFG_W{1'b1}}));

    a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg_q == $past(wdata)));

endmodule

// File: rtl/ebus_req_hold.sv
module ebus_req_hold
    import ebus_pkg::*;
#(
    parameter int AW      = 24,
    parameter int DW      = 16,
    parameter int SEL_LSB = 22
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             in_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [1:0]       req_be,
    input  logic [DW-1:0]    req_wdata,
    output req_ctl_t         cur_ctl,
    output logic [AW-1:0]    cur_addr,
    output logic [DW-1:0]    cur_wdata
);

    req_ctl_t      ctl_q, ctl_in;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    always_comb begin
        ctl_in.write = req_write;
        ctl_in.be    = req_be;
        ctl_in.space = req_addr[SEL_LSB +: SEL_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            ctl_q   <= ctl_in;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // In the ready state the live request is used, so an access can start
    // in the very cycle the request appears.
    always_comb begin
        if (in_ready) begin
            cur_ctl   = ctl_in;
            cur_addr  = req_addr;
            cur_wdata = req_wdata;
        end else begin
            cur_ctl   = ctl_q;
            cur_addr  = addr_q;
            cur_wdata = wdata_q;
        end
    end

    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !load) |=> ($stable(addr_q) && $stable(wdata_q)));

endmodule

// File: rtl/ebus_seq_fsm.sv
module ebus_seq_fsm
    import ebus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  cur_space,
    input  logic [NSPACE-1:0] spacing_en,
    input  logic [NSPACE-1:0] guard_en,
    output phase_e            phase,
    output logic              in_ready,
    output logic              guard_active,
    output logic              start
);

    state_e           st_q, st_d;
    logic             guard_q;
    logic             end_q;
    logic [SEL_W-1:0] end_sp_q;
    logic             need_gap;
    logic             last_cycle;

    // A dead cycle is due only when the previous access ended in the cycle
    // before this one and targeted the same space.
    always_comb begin
        in_ready     = (st_q == ST_READY);
        need_gap     = end_q && (end_sp_q == cur_space) && spacing_en[cur_space];
        start        = in_ready && req_valid && !need_gap;
        guard_active = in_ready ? guard_en[cur_space] : guard_q;
    end

    always_comb begin
        unique case (st_q)
            ST_READY: begin
                if (start) phase = guard_en[cur_space] ? PH_LEAD : PH_STROBE;
                else       phase = PH_IDLE;
            end
            ST_STROBE: phase = PH_STROBE;
            ST_TRAIL:  phase = PH_TRAIL;
            default:   phase = PH_IDLE;
        endcase
    end

    always_comb begin
        last_cycle = ((phase == PH_STROBE) && !guard_active) || (phase == PH_TRAIL);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_READY:  if (start && guard_en[cur_space]) st_d = ST_STROBE;
            ST_STROBE: st_d = guard_q ? ST_TRAIL : ST_READY;
            ST_TRAIL:  st_d = ST_READY;
            default:   st_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_READY;
            guard_q  <= 1'b0;
            end_q    <= 1'b0;
            end_sp_q <= '0;
        end else begin
            st_q  <= st_d;
            end_q <= last_cycle;
            if (start)      guard_q  <= guard_en[cur_space];
            if (last_cycle) end_sp_q <= cur_space;
        end
    end

    a_r4_lead_to_strobe: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LEAD) |=> (phase == PH_STROBE));

    a_r4_strobe_to_trail: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE && guard_active) |=> (phase == PH_TRAIL));

    a_r10_guard_frozen: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LEAD) |=> guard_active);

endmodule

// File: rtl/ebus_pin_drv.sv
module ebus_pin_drv
    import ebus_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  req_ctl_t          cur_ctl,
    input  logic [AW-1:0]     cur_addr,
    input  logic [DW-1:0]     cur_wdata,
    input  logic [DW-1:0]     bus_din,
    output logic [NSPACE-1:0] bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wrh_n,
    output logic              bus_wrl_n,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_doe,
    output logic              ack,
    output logic [DW-1:0]     rdata_q
);

    logic active;
    logic strobe;
    logic [NSPACE-1:0] sel;

    always_comb begin
        active = (phase != PH_IDLE);
        strobe = (phase == PH_STROBE);
        sel    = space_onehot(cur_ctl.space);
    end

    for (genvar i = 0; i < NSPACE; i++) begin : g_cs
        always_comb bus_cs_n[i] = !(active && sel[i]);
    end

    always_comb begin
        bus_rd_n  = !(strobe && !cur_ctl.write);
        bus_wrh_n = !(strobe && cur_ctl.write && cur_ctl.be[1]);
        bus_wrl_n = !(strobe && cur_ctl.write && cur_ctl.be[0]);
        bus_addr  = cur_addr;
        bus_dout  = cur_wdata;
        bus_doe   = active && cur_ctl.write;
        ack       = strobe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (strobe && !cur_ctl.write) begin
            rdata_q <= bus_din;
        end
    end

    a_r8_read_capture: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n) |=> (rdata_q == $past(bus_din)));

    a_r7_doe_needs_cs: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> (bus_cs_n != {NSPACE{1'b1}}));

endmodule

// File: rtl/ebus_strobe_seq.sv
module ebus_strobe_seq
    import ebus_pkg::*;
#(
    parameter int AW      = 24,
    parameter int DW      = 16,
    parameter int SEL_LSB = 22
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_be,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ack,
    output logic [DW-1:0]     req_rdata,
    output logic [NSPACE-1:0] bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wrh_n,
    output logic              bus_wrl_n,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_doe,
    input  logic [DW-1:0]     bus_din
);

    logic [CFG_W-1:0] cfg_q;
    phase_e           phase;
    logic             in_ready;
    logic             guard_active;
    logic             start;
    req_ctl_t         cur_ctl;
    logic [AW-1:0]    cur_addr;
    logic [DW-1:0]    cur_wdata;

    ebus_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    ebus_req_hold #(.AW(AW), .DW(DW), .SEL_LSB(SEL_LSB)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .in_ready  (in_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .cur_ctl   (cur_ctl),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata)
    );

    ebus_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .cur_space    (cur_ctl.space),
        .spacing_en   (spacing_bits(cfg_q)),
        .guard_en     (guard_bits(cfg_q)),
        .phase        (phase),
        .in_ready     (in_ready),
        .guard_active (guard_active),
        .start        (start)
    );

    ebus_pin_drv #(.AW(AW), .DW(DW)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .cur_ctl   (cur_ctl),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .bus_din   (bus_din),
        .bus_cs_n  (bus_cs_n),
        .bus_rd_n  (bus_rd_n),
        .bus_wrh_n (bus_wrh_n),
        .bus_wrl_n (bus_wrl_n),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe),
        .ack       (req_ack),
        .rdata_q   (req_rdata)
    );

    assign cfg_rdata = cfg_q;

    a_r2_cs_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));

    a_r4_strobe_inside_cs: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n || !bus_wrh_n || !bus_wrl_n) |-> (bus_cs_n != {NSPACE{1'b1}}));

    a_r4_trail_cs_only: assert property (@(posedge clk) disable iff (rst)
        (req_ack && guard_active) |=>
            ((bus_cs_n == $past(bus_cs_n)) && bus_rd_n && bus_wrh_n && bus_wrl_n));

    a_r7_trail_data_hold: assert property (@(posedge clk) disable iff (rst)
        (req_ack && bus_doe && guard_active) |=> (bus_doe && $stable(bus_dout)));

    a_r8_single_ack: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack || !guard_active);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (bus_cs_n == {NSPACE{1'b1}} || !rst) && !(rst && req_ack));

endmodule

// File: tb/sim_ebus_strobe_seq.sv
module sim_ebus_strobe_seq;

    localparam int AW = 24;
    localparam int DW = 16;
    localparam int SL = 22;

    localparam int P_IDLE = 0, P_LEAD = 1, P_STROBE = 2, P_TRAIL = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_be = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ack;
    logic [DW-1:0] req_rdata;
    logic [3:0]    bus_cs_n;
    logic          bus_rd_n, bus_wrh_n, bus_wrl_n;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout;
    logic          bus_doe;
    logic [DW-1:0] bus_din = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [7:0] m_cfg = 8'hFF;
    int m_end_cyc = -10;
    int m_end_sp = 0;
    bit rd_pend = 0;
    logic [DW-1:0] rd_exp = '0;
    bit done = 0;

    always #2 clk = ~clk;

    ebus_strobe_seq #(.AW(AW), .DW(DW), .SEL_LSB(SL)) u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wrh_n(bus_wrh_n), .bus_wrl_n(bus_wrl_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s cycle %0d: actual=%h expected=%h", tag, what, cyc, act, exp);
        end
    endtask

    // Reference pin model for one cycle of the given phase
    task automatic check_pins(input string tag, input int ph, input int sp, input bit wr,
                              input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
        logic [3:0] ecs;
        logic [5:0] act, exp;
        bit strobe;
        ecs = 4'hF;
        if (ph != P_IDLE) ecs[sp] = 1'b0;
        strobe = (ph == P_STROBE);
        exp = {ecs, !(strobe && !wr), (ph != P_IDLE) && wr};
        act = {bus_cs_n, bus_rd_n, bus_doe};
        check(tag, "cs/rd/doe", {26'd0, act}, {26'd0, exp});
        check(tag, "wrh/wrl/ack", {29'd0, bus_wrh_n, bus_wrl_n, req_ack},
              {29'd0, !(strobe && wr && be[1]), !(strobe && wr && be[0]), strobe});
        if (ph != P_IDLE) check(tag, "addr", {8'd0, bus_addr}, {8'd0, a});
        if (ph != P_IDLE && wr) check(tag, "dout", {16'd0, bus_dout}, {16'd0, d});
        if (rd_pend && ph != P_STROBE) begin
            check("R8", "rdata", {16'd0, req_rdata}, {16'd0, rd_exp});
            rd_pend = 0;
        end
    endtask

    task automatic drive(input bit v, input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] be, input logic [DW-1:0] din, input bit cw, input logic [7:0] cv);
        @(negedge clk);
        cyc++;
        req_valid = v; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        bus_din = din; cfg_we = cw; cfg_wdata = cv;
        #1;
    endtask

    task automatic idle_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            drive(0, 0, '0, '0, 2'b00, '0, 0, '0);
            check_pins(tag, P_IDLE, 0, 0, '0, '0, 2'b00);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        drive(0, 0, '0, '0, 2'b00, '0, 1, v);
        check_pins("R9", P_IDLE, 0, 0, '0, '0, 2'b00);
        m_cfg = v;
        drive(0, 0, '0, '0, 2'b00, '0, 0, '0);
        check("R9", "cfg_rdata", {24'd0, cfg_rdata}, {24'd0, v});
        check_pins("R9", P_IDLE, 0, 0, '0, '0, 2'b00);
    endtask

    // One access; starts in the cycle right after the previous call returned
    task automatic access(input string tag, input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [1:0] be, input logic [DW-1:0] din, input bit cw, input logic [7:0] cv);
        int sp;
        bit gap, ext;
        int phs[$];
        sp  = int'(a[SL +: 2]);
        gap = (m_end_cyc == cyc) && (sp == m_end_sp) && m_cfg[4 + sp];
        if (gap) begin
            drive(1, wr, a, d, be, din, 0, '0);
            check_pins("R5", P_IDLE, sp, wr, a, d, be);
        end
        ext = m_cfg[sp];
        if (ext) phs = '{P_LEAD, P_STROBE, P_TRAIL};
        else     phs = '{P_STROBE};
        foreach (phs[k]) begin
            drive(phs[k] != P_TRAIL, wr, a, d, be, din, (k == 0) && cw, cv);
            check_pins(tag, phs[k], sp, wr, a, d, be);
            if (k == 0 && cw) m_cfg = cv;
            if (phs[k] == P_STROBE && !wr) begin
                rd_pend = 1;
                rd_exp  = din;
            end
        end
        m_end_cyc = cyc;
        m_end_sp  = sp;
    endtask

    function automatic logic [AW-1:0] adr(input int sp, input int low);
        return {sp[1:0], low[21:0]};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "cs_n in reset", {28'd0, bus_cs_n}, 32'hF);
        check("R1", "strobes in reset", {29'd0, bus_rd_n, bus_wrh_n, bus_wrl_n}, 32'h7);
        check("R1", "doe/ack in reset", {30'd0, bus_doe, req_ack}, 32'h0);
        check("R9", "cfg reset", {24'd0, cfg_rdata}, 32'hFF);
        rst = 1'b0;
        idle_cycles(2, "R1");

        // Default: guard and spacing on everywhere
        access("R4", 0, adr(0, 'h123), '0, 2'b11, 16'hA5C3, 0, '0);
        access("R5", 0, adr(0, 'h124), '0, 2'b11, 16'h0F0F, 0, '0);
        access("R2", 1, adr(1, 'h200), 16'hBEEF, 2'b11, '0, 0, '0);
        idle_cycles(1, "R4");

        // Plain single-cycle mode, no spacing
        cfg_write(8'h00);
        access("R3", 1, adr(2, 'h010), 16'h1234, 2'b11, '0, 0, '0);
        access("R6", 1, adr(2, 'h011), 16'h5678, 2'b01, '0, 0, '0);
        access("R6", 1, adr(2, 'h012), 16'h9ABC, 2'b10, '0, 0, '0);
        access("R8", 0, adr(3, 'h3FF), '0, 2'b11, 16'hC0DE, 0, '0);
        access("R3", 0, adr(3, 'h3FE), '0, 2'b11, 16'h7E57, 0, '0);
        idle_cycles(1, "R8");

        // Spacing only for space 2
        cfg_write(8'h40);
        access("R5", 1, adr(2, 'h020), 16'h1111, 2'b11, '0, 0, '0);
        access("R5", 1, adr(2, 'h021), 16'h2222, 2'b11, '0, 0, '0);
        access("R5", 1, adr(1, 'h022), 16'h3333, 2'b11, '0, 0, '0);
        access("R5", 1, adr(1, 'h023), 16'h4444, 2'b11, '0, 0, '0);
        idle_cycles(2, "R5");
        access("R5", 0, adr(2, 'h024), '0, 2'b11, 16'h5555, 0, '0);
        idle_cycles(1, "R5");
        access("R5", 0, adr(2, 'h025), '0, 2'b11, 16'h6666, 0, '0);
        idle_cycles(1, "R8");

        // Guard on space 0; configuration cleared during the lead cycle
        cfg_write(8'h01);
        access("R10", 1, adr(0, 'h030), 16'hD00D, 2'b11, '0, 1, 8'h00);
        check("R10", "cfg_rdata", {24'd0, cfg_rdata}, 32'h00);
        access("R10", 1, adr(0, 'h031), 16'hFACE, 2'b10, '0, 0, '0);
        idle_cycles(1, "R7");

        // Guard with spacing on space 3, writes back to back
        cfg_write(8'h88);
        access("R7", 1, adr(3, 'h040), 16'hAAAA, 2'b01, '0, 0, '0);
        access("R7", 1, adr(3, 'h041), 16'hBBBB, 2'b11, '0, 0, '0);
        access("R4", 0, adr(0, 'h042), '0, 2'b11, 16'h4321, 0, '0);
        idle_cycles(2, "R8");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule